// File: doc/BRIEF.md
# MDIO Management Master with Register Interface

This block lets software reach PHY management registers over the two-wire MDC/MDIO bus. Four 32-bit words of a register window hold the configuration and status word, the control word, the data word and the extended-address word. Software selects the frame style with one bit in the configuration word. The legacy style puts a 5-bit register number in the control word. The extended style puts a 5-bit device number there and a separate 16-bit register address in the address word.

A transaction starts when software writes a specific register. Writing the address word in extended mode sends an address frame. Writing the data word sends a write frame. Writing the control word with its read bit set sends a read frame. While a frame is on the wire a busy flag is visible, and writes to the window are refused. A read captures sixteen bits from the PHY into the data word. It flags an error if no PHY pulled the line low during the second turnaround bit.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the block is idle. Busy reads 0, mdio_oe is 0, mdc is low, and every readable register field reads 0.
- R2: The register layout is as follows. Word 12 is configuration/status: bit 0 busy, bit 1 read error, bit 6 extended framing, bits 15:8 divider. Word 13 is control: bits 4:0 device/register number, bits 9:5 port, bit 10 preamble off, bit 15 read request, which always reads 0. Word 14 is data: bits 15:0 value, bit 31 mirrors busy. Word 15 is the address word, bits 15:0. The writable fields read back as written.
- R3: mdc is low while idle. During a frame its period is 2*(divider+1) system clocks, starting low.
- R4: A frame is 32 one-bits of preamble followed by a 32-bit body, sent MSB first. The body is start(2), opcode(2), port(5), device(5), turnaround(2) and value(16). With preamble off, only the 32-bit body is sent.
- R5: Legacy framing uses start 01, with opcode 01 for a write and 10 for a read.
- R6: Extended framing uses start 00, with opcode 00 for an address frame, 01 for a write and 11 for a read. An address-word write sends an address frame only in extended mode. In legacy mode the value is only stored.
- R7: A data-word write sends a write frame with turnaround 10. The frame uses the port and device held in the control word. Busy is 1 from the clock after the write until the frame ends.
- R8: A control write with bit 15 set sends a read frame using the newly written port and device. The master releases MDIO from the first turnaround bit onward. When busy clears, the 16 sampled bits are in the data word.
- R9: The read-error flag is set when the second turnaround bit is sampled high. It is cleared when the next frame starts.
- R10: Any register write while busy is 1 is ignored. It starts nothing and changes no stored field.
- R11: While a frame runs, mdio_o changes only on a falling mdc edge. MDIO input is sampled on the rising mdc edge.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wen | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write word index |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read word index |
| reg_rdata | output | 32 | Read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen on the bus |

## Verification
If the bit counter or shift register goes wrong, the captured frame is off. The frame has the wrong length, or a field appears in the wrong position. This shows in the bit stream at the first wrong mdc edge and in the total rise count once busy clears. If the turnaround release or sampling point is wrong, the master and the PHY fight on the line. It can also show as a bad read value or a wrong error flag as soon as busy falls. If the busy gating is broken, an extra frame appears or stored fields get corrupted. The first register readback after the frame shows it.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
    localparam int REG_W      = 32;
    localparam int VAL_W      = 16;
    localparam int PHYA_W     = 5;
    localparam int BODY_W     = 32;
    localparam int PRE_LEN    = 32;
    localparam int FRAME_MAX  = PRE_LEN + BODY_W;
    localparam int NBIT_W     = $clog2(FRAME_MAX + 1);
    localparam int DIV_W      = 8;

    localparam logic [3:0] WI_CFG  = 4'd12;
    localparam logic [3:0] WI_CTL  = 4'd13;
    localparam logic [3:0] WI_DATA = 4'd14;
    localparam logic [3:0] WI_ADDR = 4'd15;

    typedef enum logic [1:0] {
        FK_ADDR  = 2'd0,
        FK_WRITE = 2'd1,
        FK_READ  = 2'd2
    } frame_kind_e;

    typedef struct packed {
        logic              ext;
        logic              no_pre;
        logic [PHYA_W-1:0] port;
        logic [PHYA_W-1:0] dev;
        logic [VAL_W-1:0]  payload;
        frame_kind_e       kind;
    } frame_req_t;

    typedef struct packed {
        logic [FRAME_MAX-1:0] bits;
        logic [NBIT_W-1:0]    nbits;
        logic                 is_read;
    } frame_t;

    function automatic frame_t build_frame(input frame_req_t r);
        frame_t            f;
        logic [1:0]        st;
        logic [1:0]        op;
        logic [BODY_W-1:0] body;
        if (r.ext) begin
            st = 2'b00;
            case (r.kind)
                FK_ADDR:  op = 2'b00;
                FK_WRITE: op = 2'b01;
                default:  op = 2'b11;
            endcase
        end else begin
            st = 2'b01;
            op = (r.kind == FK_READ) ? 2'b10 : 2'b01;
        end
        body = {st, op, r.port, r.dev, 2'b10, r.payload};
        if (r.no_pre) begin
            f.bits  = {body, {PRE_LEN{1'b0}}};
            f.nbits = NBIT_W'(BODY_W);
        end else begin
            f.bits  = {{PRE_LEN{1'b1}}, body};
            f.nbits = NBIT_W'(FRAME_MAX);
        end
        f.is_read = (r.kind == FK_READ);
        return f;
    endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_p,
    output logic             fall_p
);
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick   = run && (cnt == div);
    assign rise_p = tick && !mdc;
    assign fall_p = tick && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  frame_t           frm,
    input  logic             rise_p,
    input  logic             fall_p,
    input  logic             mdio_i,
    output logic             busy,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             rd_done,
    output logic [VAL_W-1:0] rx_data,
    output logic             rd_err
);
    localparam logic [NBIT_W-1:0] TA_FIRST  = NBIT_W'(VAL_W + 2);
    localparam logic [NBIT_W-1:0] TA_SECOND = NBIT_W'(VAL_W + 1);
    localparam logic [NBIT_W-1:0] LAST_VAL  = NBIT_W'(VAL_W);

    logic [FRAME_MAX-1:0] sh;
    logic [NBIT_W-1:0]    remain;
    logic                 is_rd;
    logic                 last_fall;

    assign last_fall = busy && fall_p && (remain == NBIT_W'(1));
    assign rd_done   = last_fall && is_rd;
    assign mdio_o    = busy && sh[FRAME_MAX-1];
    assign mdio_oe   = busy && !(is_rd && (remain <= TA_FIRST));

    always_ff @(posedge clk) begin
        if (rst) begin
            sh      <= '0;
            remain  <= '0;
            busy    <= 1'b0;
            is_rd   <= 1'b0;
            rx_data <= '0;
            rd_err  <= 1'b0;
        end else if (start && !busy) begin
            sh      <= frm.bits;
            remain  <= frm.nbits;
            busy    <= 1'b1;
            is_rd   <= frm.is_read;
            rx_data <= '0;
            rd_err  <= 1'b0;
        end else if (busy) begin
            if (rise_p && is_rd) begin
                if (remain == TA_SECOND && mdio_i)
                    rd_err <= 1'b1;
                if (remain <= LAST_VAL)
                    rx_data <= {rx_data[VAL_W-2:0], mdio_i};
            end
            if (fall_p) begin
                if (last_fall) begin
                    busy <= 1'b0;
                end else begin
                    sh     <= sh << 1;
                    remain <= remain - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
    import mdio_mgmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wen,
    input  logic [3:0]       waddr,
    input  logic [REG_W-1:0] wdata,
    input  logic [3:0]       raddr,
    output logic [REG_W-1:0] rdata,
    input  logic             busy,
    input  logic             rd_done,
    input  logic [VAL_W-1:0] rx_data,
    input  logic             rd_err,
    output logic             start,
    output frame_req_t       req,
    output logic [DIV_W-1:0] div
);
    logic              ext_q;
    logic              nopre_q;
    logic [PHYA_W-1:0] port_q;
    logic [PHYA_W-1:0] dev_q;
    logic [VAL_W-1:0]  data_q;
    logic [VAL_W-1:0]  addr_q;
    logic              accept;

    assign accept = wen && !busy;
    assign div    = '0 | div_q_w;

    logic [DIV_W-1:0] div_q_w;

    always_comb begin
        start       = 1'b0;
        req.ext     = ext_q;
        req.no_pre  = nopre_q;
        req.port    = port_q;
        req.dev     = dev_q;
        req.payload = wdata[VAL_W-1:0];
        req.kind    = FK_WRITE;
        case (waddr)
            WI_CTL: begin
                start       = accept && wdata[15];
                req.kind    = FK_READ;
                req.no_pre  = wdata[10];
                req.port    = wdata[9:5];
                req.dev     = wdata[4:0];
                req.payload = '1;
            end
            WI_DATA: start = accept;
            WI_ADDR: begin
                start    = accept && ext_q;
                req.kind = FK_ADDR;
            end
            default: start = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q   <= 1'b0;
            nopre_q <= 1'b0;
            port_q  <= '0;
            dev_q   <= '0;
            data_q  <= '0;
            addr_q  <= '0;
            div_q_w <= '0;
        end else begin
            if (accept) begin
                case (waddr)
                    WI_CFG: begin
                        div_q_w <= wdata[15:8];
                        ext_q   <= wdata[6];
                    end
                    WI_CTL: begin
                        nopre_q <= wdata[10];
                        port_q  <= wdata[9:5];
                        dev_q   <= wdata[4:0];
                    end
                    WI_DATA: data_q <= wdata[VAL_W-1:0];
                    WI_ADDR: addr_q <= wdata[VAL_W-1:0];
                    default: ;
                endcase
            end
            if (rd_done)
                data_q <= rx_data;
        end
    end

    always_comb begin
        case (raddr)
            WI_CFG:  rdata = {16'h0, div_q_w, 1'b0, ext_q, 4'h0, rd_err, busy};
            WI_CTL:  rdata = {16'h0, 1'b0, 4'h0, nopre_q, port_q, dev_q};
            WI_DATA: rdata = {busy, 15'h0, data_q};
            WI_ADDR: rdata = {16'h0, addr_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_mgmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wen,
    input  logic [3:0]  reg_waddr,
    input  logic [31:0] reg_wdata,
    input  logic [3:0]  reg_raddr,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic             start;
    frame_req_t       req;
    frame_t           frm;
    logic [DIV_W-1:0] div;
    logic             eng_busy;
    logic             eng_err;
    logic             rd_done;
    logic [VAL_W-1:0] rx_data;
    logic             rise_p;
    logic             fall_p;

    assign frm = build_frame(req);

    mdio_reg_file u_regs (
        .clk(clk), .rst(rst),
        .wen(reg_wen), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .rdata(reg_rdata),
        .busy(eng_busy), .rd_done(rd_done), .rx_data(rx_data), .rd_err(eng_err),
        .start(start), .req(req), .div(div)
    );

    mdio_mdc_gen u_mdc (
        .clk(clk), .rst(rst), .run(eng_busy), .div(div),
        .mdc(mdc), .rise_p(rise_p), .fall_p(fall_p)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst(rst), .start(start), .frm(frm),
        .rise_p(rise_p), .fall_p(fall_p), .mdio_i(mdio_i),
        .busy(eng_busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .rd_done(rd_done), .rx_data(rx_data), .rd_err(eng_err)
    );
endmodule

// File: rtl/mdio_mgmt_sva.sv
module mdio_mgmt_sva (
    input logic clk,
    input logic rst,
    input logic mdc,
    input logic mdio_o,
    input logic mdio_oe,
    input logic busy,
    input logic rd_err,
    input logic reg_wen
);
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdio_oe);

    a_r3_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mdc);

    a_r7_busy_from_write: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wen));

    a_r8_release_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$past(mdio_oe)) |-> !mdio_oe);

    a_r9_err_in_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_err) |-> busy);

    a_r11_out_on_fall: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));
endmodule

bind mdio_mgmt_master mdio_mgmt_sva u_sva (
    .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(eng_busy), .rd_err(eng_err), .reg_wen(reg_wen)
);

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wen = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;
    logic        phy_drv = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rise_cnt = 0;
    int base = 0;
    logic [63:0] cap = '0;
    logic [63:0] phy_resp = '1;

    assign mdio_i = mdio_oe ? mdio_o : phy_drv;

    mdio_mgmt_master dut (
        .clk(clk), .rst(rst), .reg_wen(reg_wen), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: act=running exp=finished");
            summary();
        end
    end

    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_i};
        rise_cnt++;
    end

    always @(negedge mdc) begin
        if (rise_cnt - base < 64) phy_drv = phy_resp[63 - (rise_cnt - base)];
        else phy_drv = 1'b1;
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_wen = 1'b1; reg_waddr = idx; reg_wdata = val;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] val);
        @(negedge clk);
        reg_raddr = idx;
        #1 val = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd(4'd12, v);
            if (!v[0]) return;
        end
        n_chk++; n_fail++;
        $display("FAIL busy stuck: act=1 exp=0");
    endtask

    function automatic logic [31:0] body(input logic ext, input logic [1:0] op,
        input logic [4:0] port, input logic [4:0] dev, input logic [1:0] ta,
        input logic [15:0] val);
        return {ext ? 2'b00 : 2'b01, op, port, dev, ta, val};
    endfunction

    function automatic logic [63:0] resp_of(input logic pre, input logic [15:0] val);
        logic [31:0] r = {15'h7FFF, 1'b0, val};
        return pre ? {32'hFFFF_FFFF, r} : {r, 32'hFFFF_FFFF};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 mdio_oe", {63'h0, mdio_oe}, 64'h0);
        chk("R1 mdc", {63'h0, mdc}, 64'h0);
        rd(4'd12, v); chk("R1 cfg", {32'h0, v}, 64'h0);
        rd(4'd14, v); chk("R1 data", {32'h0, v}, 64'h0);
    endtask

    task automatic t_cfg_and_mdc();
        logic [31:0] v;
        time t0, t1;
        wr(4'd12, 32'h0000_0240);
        rd(4'd12, v); chk("R2 cfg readback", {32'h0, v}, 64'h0240);
        wr(4'd13, 32'h0000_8000 | (5'd3 << 5) | 5'd1);
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        chk("R3 mdc period", 64'((t1 - t0) / CLK_PERIOD), 64'd6);
        wait_idle();
        rd(4'd13, v); chk("R2 ctl readback, read bit 0", {32'h0, v}, 64'h0061);
        wr(4'd12, 32'h0000_0100);
    endtask

    task automatic t_c22_write();
        logic [31:0] v;
        wr(4'd13, (5'd5 << 5) | 5'd9);
        base = rise_cnt; phy_resp = '1;
        wr(4'd14, 32'h0000_A5C3);
        rd(4'd14, v); chk("R7 data bit31 busy", {63'h0, v[31]}, 64'h1);
        wait_idle();
        chk("R4 frame length", 64'(rise_cnt - base), 64'd64);
        chk("R5 R7 c22 write frame", cap,
            {32'hFFFF_FFFF, body(1'b0, 2'b01, 5'd5, 5'd9, 2'b10, 16'hA5C3)});
    endtask

    task automatic t_c22_read();
        logic [31:0] v;
        base = rise_cnt; phy_resp = resp_of(1'b1, 16'h3C5A);
        wr(4'd13, 32'h0000_8000 | (5'd7 << 5) | 5'd2);
        wait_idle();
        chk("R5 R8 c22 read frame", cap,
            {32'hFFFF_FFFF, body(1'b0, 2'b10, 5'd7, 5'd2, 2'b10, 16'h3C5A)});
        rd(4'd14, v); chk("R8 read value", {32'h0, v}, 64'h3C5A);
        rd(4'd12, v); chk("R9 no error", {63'h0, v[1]}, 64'h0);
    endtask

    task automatic t_no_phy();
        logic [31:0] v;
        base = rise_cnt; phy_resp = '1;
        wr(4'd13, 32'h0000_8000 | (5'd8 << 5) | 5'd1);
        wait_idle();
        rd(4'd12, v); chk("R9 error set", {63'h0, v[1]}, 64'h1);
        base = rise_cnt;
        wr(4'd14, 32'h0000_0001);
        rd(4'd12, v); chk("R9 error cleared on start", {63'h0, v[1]}, 64'h0);
        wait_idle();
    endtask

    task automatic t_c45();
        logic [31:0] v;
        wr(4'd12, 32'h0000_0140);
        wr(4'd13, (5'd4 << 5) | 5'd30);
        base = rise_cnt; phy_resp = '1;
        wr(4'd15, 32'h0000_1234);
        wait_idle();
        chk("R6 c45 address frame", cap,
            {32'hFFFF_FFFF, body(1'b1, 2'b00, 5'd4, 5'd30, 2'b10, 16'h1234)});
        base = rise_cnt;
        wr(4'd14, 32'h0000_BEEF);
        wait_idle();
        chk("R6 c45 write frame", cap,
            {32'hFFFF_FFFF, body(1'b1, 2'b01, 5'd4, 5'd30, 2'b10, 16'hBEEF)});
        base = rise_cnt; phy_resp = resp_of(1'b1, 16'h0F0F);
        wr(4'd13, 32'h0000_8000 | (5'd4 << 5) | 5'd30);
        wait_idle();
        chk("R6 c45 read frame", cap,
            {32'hFFFF_FFFF, body(1'b1, 2'b11, 5'd4, 5'd30, 2'b10, 16'h0F0F)});
        rd(4'd14, v); chk("R8 c45 read value", {32'h0, v}, 64'h0F0F);
    endtask

    task automatic t_no_pre();
        logic [31:0] v;
        base = rise_cnt; phy_resp = resp_of(1'b0, 16'h8001);
        wr(4'd13, 32'h0000_8400 | (5'd2 << 5) | 5'd3);
        wait_idle();
        chk("R4 no preamble length", 64'(rise_cnt - base), 64'd32);
        chk("R4 no preamble frame", {32'h0, cap[31:0]},
            {32'h0, body(1'b1, 2'b11, 5'd2, 5'd3, 2'b10, 16'h8001)});
        rd(4'd14, v); chk("R8 value without preamble", {32'h0, v}, 64'h8001);
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(4'd12, 32'h0000_0100);
        wr(4'd13, (5'd1 << 5) | 5'd1);
        base = rise_cnt; phy_resp = '1;
        wr(4'd14, 32'h0000_1111);
        wr(4'd14, 32'h0000_2222);
        wr(4'd12, 32'h0000_0540);
        wait_idle();
        chk("R10 single frame", 64'(rise_cnt - base), 64'd64);
        rd(4'd14, v); chk("R10 data unchanged", {32'h0, v}, 64'h1111);
        rd(4'd12, v); chk("R10 cfg unchanged", {32'h0, v}, 64'h0100);
    endtask

    task automatic t_c22_addr_store();
        logic [31:0] v;
        base = rise_cnt;
        wr(4'd15, 32'h0000_7777);
        rd(4'd12, v); chk("R6 no frame in legacy mode", {63'h0, v[0]}, 64'h0);
        repeat (20) @(negedge clk);
        chk("R6 no mdc edges", 64'(rise_cnt - base), 64'd0);
        rd(4'd15, v); chk("R2 address readback", {32'h0, v}, 64'h7777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cfg_and_mdc();
        t_c22_write();
        t_c22_read();
        t_no_phy();
        t_c45();
        t_no_pre();
        t_busy_ignore();
        t_c22_addr_store();
        summary();
    end
endmodule